// File: doc/BRIEF.md
# Multiplexed LCD Backplane Scan Sequencer

This block steps a dot-matrix liquid crystal panel of up to 8 rows and 24 columns through its time-multiplexed refresh. It is clocked by the refresh oscillator. Every row (backplane) owns a slot of four oscillator ticks. A frame therefore lasts four times the programmed row count. The block emits a 2-bit level-select code for every row line and every column line. An external resistor ladder turns these codes into drive voltages. The polarity flips on every tick, so each line's code in an odd tick is the mirror of its code in the preceding even tick. That keeps the average DC voltage between any row and column at zero.

The block exposes the row it is scanning, and the display memory returns that row's 24 column bits in the same cycle. While the serial host interface is busy with an access, the columns are driven with the "off" level and do not show memory contents. Several devices can be cascaded. A master drives the row-1 line and raises a frame marker at the start of every frame. A slave leaves row 1 undriven. It takes the master's marker on its sync input and realigns its own scan on each rising edge of that marker.

Top module: `lcd_scan_seq`

## Requirements
- R1: After reset the scan is at row 0, tick 0 of its slot, so `scan_row` is 0 and a master raises `sync_out`.
- R2: The tick index within a slot advances 0,1,2,3 on successive clocks. After tick 3, the row advances by one.
- R3: The row-count code `rows_code` gives h = code+1 rows for codes 1 to 7. Code 0 is treated as 2 rows. A frame is exactly 4*h clocks, measured between successive `sync_out` pulses of a master.
- R4: Row line codes: the scanned row gives 3 in even ticks and 0 in odd ticks. Every other row line gives 1 in even ticks and 2 in odd ticks. Exactly one row line is the scanned one.
- R5: Column line codes: a column whose memory bit `row_bits[j]` is 1 gives 0 in even ticks and 3 in odd ticks. A column whose bit is 0 gives 2 in even ticks and 1 in odd ticks. Column j occupies bits [2j+1:2j] of `col_lvl`, and row i occupies bits [2i+1:2i] of `row_lvl`.
- R6: While `host_busy` is 1, every column gives the "off" codes of R5, whatever the memory bits are.
- R7: With `is_master`=1, `row1_oe` is 1 and `sync_out` is 1 exactly in tick 0 of row 0. With `is_master`=0, both outputs are 0.
- R8: A slave that sees `sync_in` rise (0 in the previous clock, 1 now) treats the current clock as tick 0 of row 0, so the next clock is tick 1 of row 0. A master ignores `sync_in`, and so does a slave while `sync_in` stays high.
- R9: In every odd tick that does not directly follow a resynchronisation, each row line's code is the bitwise inverse of its code in the previous clock (zero net DC).
- R10: If the row count is lowered while the scan is on a row at or beyond the new last row, the scan returns to row 0 when the current slot ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Refresh oscillator clock |
| rst_n | input | 1 | Active-low reset |
| rows_code | input | 3 | Programmed row count minus one |
| is_master | input | 1 | 1 = master, 0 = slave |
| host_busy | input | 1 | Serial interface is accessing the memory |
| sync_in | input | 1 | Row-1 frame marker from the master |
| row_bits | input | 24 | Column bits of the row addressed by `scan_row` |
| scan_row | output | 3 | Row currently scanned (memory read address) |
| row_lvl | output | 16 | 2-bit level code per row line |
| col_lvl | output | 48 | 2-bit level code per column line |
| row1_oe | output | 1 | Enable for the row-1 line driver |
| sync_out | output | 1 | Frame-start marker (master only) |

## Verification
The bench looks for frames of the wrong length for every row-count code, including the out-of-table code 0. A miscounted wrap would show up as a `sync_out` interval other than 4*h. It lowers the row count while the scan sits past the new last row; a design with an equality-only wrap would run on to row 7 and beyond. It pulses `sync_in` on masters and slaves, and holds it high on a slave. A design that resynchronised on level, or on a master, would jump the row mid-frame. It raises `host_busy` over rows full of set bits, where leaking memory contents would show as outer-level column codes.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int CODE_W = 3;

  typedef logic [1:0] lvl_t;
  localparam lvl_t LV_BOT  = 2'd0;
  localparam lvl_t LV_LMID = 2'd1;
  localparam lvl_t LV_UMID = 2'd2;
  localparam lvl_t LV_TOP  = 2'd3;

  // last row index for a row-count code (code 0 behaves as two rows)
  function automatic logic [CODE_W-1:0] last_row_of(logic [CODE_W-1:0] code);
    return (code == '0) ? CODE_W'(1) : code;
  endfunction

  // row line: selected row swings to the outer rails, others sit mid-ladder
  function automatic lvl_t row_level(logic selected, logic neg);
    if (selected) return neg ? LV_BOT : LV_TOP;
    return neg ? LV_UMID : LV_LMID;
  endfunction

  // column line: lit pixel opposes the selected row, dark pixel stays inner
  function automatic lvl_t col_level(logic lit, logic neg);
    if (lit) return neg ? LV_TOP : LV_BOT;
    return neg ? LV_LMID : LV_UMID;
  endfunction
endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcd_scan_pkg::*;
#(
  parameter int ROWS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] rows_code,
  input  logic              is_master,
  input  logic              sync_in,
  output logic [CODE_W-1:0] row,
  output logic              neg,
  output logic              frame_start,
  output logic              load_sync,
  output logic              paired
);
  localparam logic [CODE_W-1:0] MAX_ROW = CODE_W'(ROWS - 1);

  logic [1:0]        tick;
  logic              sync_q;
  logic              jumped_q;
  logic [CODE_W-1:0] last_raw;
  logic [CODE_W-1:0] last_row;
  logic              slot_end;

  always_comb begin
    last_raw    = last_row_of(rows_code);
    last_row    = (last_raw > MAX_ROW) ? MAX_ROW : last_raw;
    load_sync   = !is_master && sync_in && !sync_q;
    slot_end    = (tick == 2'd3);
    neg         = tick[0];
    frame_start = (row == '0) && (tick == 2'd0);
    paired      = tick[0] && !jumped_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row      <= '0;
      tick     <= 2'd0;
      sync_q   <= 1'b0;
      jumped_q <= 1'b0;
    end else begin
      sync_q   <= sync_in;
      jumped_q <= load_sync;
      if (load_sync) begin
        row  <= '0;
        tick <= 2'd1;
      end else if (slot_end) begin
        tick <= 2'd0;
        row  <= (row >= last_row) ? '0 : row + CODE_W'(1);
      end else begin
        tick <= tick + 2'd1;
      end
    end
  end

  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_sync |=> tick == $past(tick) + 2'd1);

  assert_row_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_sync && !slot_end) |=> row == $past(row));

  assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_end && !load_sync && row >= last_row) |=> row == '0);

  assert_slave_align_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_sync |=> (row == '0 && tick == 2'd1));
endmodule

// File: rtl/lcd_scan_rowdrv.sv
module lcd_scan_rowdrv
  import lcd_scan_pkg::*;
#(
  parameter int ROWS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] row,
  input  logic              neg,
  input  logic              paired,
  output logic [2*ROWS-1:0] row_lvl
);
  logic [ROWS-1:0] sel;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    assign sel[i] = (row == CODE_W'(i));
    assign row_lvl[2*i +: 2] = row_level(sel[i], neg);

    assert_row_dc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      paired |-> row_lvl[2*i +: 2] == ~$past(row_lvl[2*i +: 2]));
  end

  assert_one_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel) == 1);
endmodule

// File: rtl/lcd_scan_coldrv.sv
module lcd_scan_coldrv
  import lcd_scan_pkg::*;
#(
  parameter int COLS = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [COLS-1:0]   row_bits,
  input  logic              neg,
  input  logic              host_busy,
  output logic [2*COLS-1:0] col_lvl
);
  for (genvar j = 0; j < COLS; j++) begin : g_col
    assign col_lvl[2*j +: 2] = col_level(row_bits[j] && !host_busy, neg);

    assert_busy_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
      host_busy |-> (col_lvl[2*j+1] ^ col_lvl[2*j]));
  end
endmodule

// File: rtl/lcd_scan_seq.sv
module lcd_scan_seq
  import lcd_scan_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        rows_code,
  input  logic              is_master,
  input  logic              host_busy,
  input  logic              sync_in,
  input  logic [COLS-1:0]   row_bits,
  output logic [2:0]        scan_row,
  output logic [2*ROWS-1:0] row_lvl,
  output logic [2*COLS-1:0] col_lvl,
  output logic              row1_oe,
  output logic              sync_out
);
  logic neg;
  logic frame_start;
  logic load_sync;
  logic paired;

  lcd_scan_timer #(.ROWS(ROWS)) u_timer (
    .clk(clk), .rst_n(rst_n), .rows_code(rows_code), .is_master(is_master),
    .sync_in(sync_in), .row(scan_row), .neg(neg), .frame_start(frame_start),
    .load_sync(load_sync), .paired(paired)
  );

  lcd_scan_rowdrv #(.ROWS(ROWS)) u_rows (
    .clk(clk), .rst_n(rst_n), .row(scan_row), .neg(neg), .paired(paired),
    .row_lvl(row_lvl)
  );

  lcd_scan_coldrv #(.COLS(COLS)) u_cols (
    .clk(clk), .rst_n(rst_n), .row_bits(row_bits), .neg(neg),
    .host_busy(host_busy), .col_lvl(col_lvl)
  );

  assign row1_oe  = is_master;
  assign sync_out = is_master && frame_start;

  assert_slave_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> (!row1_oe && !sync_out));

  assert_master_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |-> !load_sync);
endmodule

// File: tb/lcd_scan_seq_test.sv
module lcd_scan_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  rows_code = 3'd7;
  logic        is_master = 1'b1;
  logic        host_busy = 1'b0;
  logic        sync_in = 1'b0;
  logic [23:0] row_bits;
  logic [2:0]  scan_row;
  logic [15:0] row_lvl;
  logic [47:0] col_lvl;
  logic        row1_oe;
  logic        sync_out;

  always #5 clk = ~clk;

  lcd_scan_seq uut (
    .clk(clk), .rst_n(rst_n), .rows_code(rows_code), .is_master(is_master),
    .host_busy(host_busy), .sync_in(sync_in), .row_bits(row_bits),
    .scan_row(scan_row), .row_lvl(row_lvl), .col_lvl(col_lvl),
    .row1_oe(row1_oe), .sync_out(sync_out)
  );

  // reference model state
  logic [23:0] mem [8];
  int m_row = 0, m_tick = 0;
  bit m_syncq = 0, m_jump = 0;
  logic [15:0] prev_row_lvl = '0;
  int tests = 0, fails = 0;
  bit done = 0;

  assign row_bits = mem[m_row[2:0]];

  function automatic int rows_for(logic [2:0] c);
    return (c == 3'd0) ? 2 : int'(c) + 1;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_advance();
    bit ld;
    ld = !is_master && sync_in && !m_syncq;
    m_syncq = sync_in;
    m_jump = ld;
    if (ld) begin
      m_row = 0; m_tick = 1;
    end else if (m_tick == 3) begin
      m_tick = 0;
      m_row = (m_row >= rows_for(rows_code) - 1) ? 0 : m_row + 1;
    end else m_tick++;
  endtask

  task automatic compare_all();
    bit odd = (m_tick % 2) == 1;
    int exp_r, exp_c, bad_r, bad_c;
    bit lit;
    chk(scan_row == 3'(m_row), "R2", "scan_row", scan_row, m_row);
    bad_r = -1;
    for (int i = 0; i < 8; i++) begin
      if (i == m_row) exp_r = odd ? 0 : 3; else exp_r = odd ? 2 : 1;
      if (int'(row_lvl[2*i +: 2]) != exp_r && bad_r < 0) bad_r = i;
    end
    chk(bad_r < 0, "R4", "row level mismatch at row index", bad_r, -1);
    bad_c = -1;
    for (int j = 0; j < 24; j++) begin
      lit = mem[m_row[2:0]][j] && !host_busy;
      if (lit) exp_c = odd ? 3 : 0; else exp_c = odd ? 1 : 2;
      if (int'(col_lvl[2*j +: 2]) != exp_c && bad_c < 0) bad_c = j;
    end
    chk(bad_c < 0, host_busy ? "R6" : "R5", "column level mismatch at column", bad_c, -1);
    chk(row1_oe == is_master, "R7", "row1_oe", row1_oe, is_master);
    chk(sync_out == (is_master && m_row == 0 && m_tick == 0), "R7", "sync_out",
        sync_out, int'(is_master && m_row == 0 && m_tick == 0));
    if (odd && !m_jump)
      chk(row_lvl == ~prev_row_lvl, "R9", "row levels not inverted", row_lvl, ~prev_row_lvl);
    prev_row_lvl = row_lvl;
  endtask

  task automatic step();
    @(posedge clk);
    model_advance();
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic measure_frame(logic [2:0] c);
    int n;
    rows_code = c;
    while (!sync_out) step();
    step();
    n = 1;
    while (!sync_out) begin step(); n++; end
    chk(n == 4 * rows_for(c), "R3", "frame length", n, 4 * rows_for(c));
  endtask

  initial begin
    for (int r = 0; r < 8; r++) mem[r] = 24'h5A5A5A ^ (24'h010203 * r);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(scan_row == 3'd0, "R1", "scan_row after reset", scan_row, 0);
    chk(sync_out == 1'b1, "R1", "sync_out after reset", sync_out, 1);
    compare_all();
    run(70);
    // R3 every code, including code 0
    for (int c = 0; c < 8; c++) measure_frame(3'(c));
    // R5 other patterns
    rows_code = 3'd7;
    for (int r = 0; r < 8; r++) mem[r] = (r % 2 == 0) ? 24'hFFFFFF : 24'h000000;
    run(40);
    // R6 busy over rows full of set bits
    host_busy = 1'b1;
    run(40);
    host_busy = 1'b0;
    for (int r = 0; r < 8; r++) mem[r] = 24'h800001 << r;
    run(40);
    // R10 shrink while scanning row 6
    rows_code = 3'd7;
    while (!(m_row == 6 && m_tick == 1)) step();
    rows_code = 3'd2;
    run(3);
    chk(scan_row == 3'd0, "R10", "row after shrink wrap", scan_row, 0);
    run(30);
    // R8 master ignores sync_in
    rows_code = 3'd7;
    run(9);
    sync_in = 1'b1; step(); sync_in = 1'b0;
    run(6);
    chk(scan_row != 3'd0 || m_row == 0, "R8", "master row after sync pulse", scan_row, m_row);
    // R8 slave resynchronises on rising edge only
    is_master = 1'b0;
    run(13);
    sync_in = 1'b1; step();
    chk(scan_row == 3'd0, "R8", "slave row after sync edge", scan_row, 0);
    run(10);
    chk(scan_row == 3'd2, "R8", "slave holds scan while sync high", scan_row, 2);
    sync_in = 1'b0;
    run(17);
    sync_in = 1'b1; step(); sync_in = 1'b0;
    run(20);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule